// File: doc/BRIEF.md
# Shift and Rotate Execution Unit

This block is the shift/rotate slice of an integer execution pipeline. Each cycle it may accept one operation. The operation names an opcode, an operand size (8, 16 or 32 bits), a destination value, a second source value (used only by the two-operand funnel shifts), a count and the incoming carry flag. One clock edge later it presents the result and the new carry flag on registered outputs.

The count is reduced to its low five bits. A reduced count of zero leaves both the value and the carry untouched. Plain shifts and rotates work on the selected width. The rotates through carry work on a ring that is one bit wider than the operand, with the carry flag as its extra bit. The funnel shifts treat the destination and the second source as one double-width value and shift it. Operand bits above the selected width are ignored on input and read as zero on output.

Top module: `shrot_unit`

## Requirements
- R1: With `in_valid` high at a rising edge, `out_valid` is high after that edge and `result`/`cf_out` carry that operation's outcome. With `in_valid` low, `out_valid` drops and `result`/`cf_out` hold their values. Synchronous reset clears all three outputs to zero.
- R2: Only `count[4:0]` is used, so bits 7:5 have no effect. A used count of zero returns the destination (masked to the width) with `cf_out` equal to `cf_in`.
- R3: `size` code 0 selects 8 bits, code 1 selects 16 bits, and codes 2 and 3 select 32 bits. Input bits above the width are ignored and output bits above the width are zero.
- R4: Opcode 0 (logical left) and opcode 2 (arithmetic left) behave identically. Vacated low bits fill with 0, and the carry is the last bit shifted out of the top (0 once the count exceeds the width).
- R5: Opcode 1 (logical right) fills vacated high bits with 0. The carry is destination bit count-1, or 0 when the count exceeds the width.
- R6: Opcode 3 (arithmetic right) fills vacated high bits with the original sign bit. The carry is the last bit shifted out of bit 0, which is the sign bit once the count reaches the width.
- R7: Opcode 4 rotates left by the count modulo the width, and the carry equals result bit 0. For example, 8-bit 3Fh rotated by 4 gives F3h.
- R8: Opcode 5 rotates right by the count modulo the width, and the carry equals the result's top bit.
- R9: Opcodes 6 (left) and 7 (right) rotate the ring {carry, operand} of width+1 bits by the count modulo width+1. The new carry is the ring's top bit.
- R10: Opcode 8 shifts the double value {destination, source} left and returns its upper half, so the low bits fill from the source's top bits. The carry is the last bit out of the top. Example: 16-bit 9BA6h, AC36h, count 4 gives BA6Ah.
- R11: Opcode 9 shifts {source, destination} right and returns the lower half, so the high bits fill from the source's low bits. The carry is the last bit out of bit 0. Example: 16-bit 234Bh, 7654h, count 4 gives 4234h.
- R12: Opcodes 8 and 9 at 8-bit size, and opcodes 10 to 15 at any size, return the masked destination with the carry unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 4 | Opcode |
| size | input | 2 | Operand size code |
| dst | input | 32 | Destination operand |
| src | input | 32 | Second source for funnel shifts |
| count | input | 8 | Shift/rotate count |
| cf_in | input | 1 | Incoming carry flag |
| out_valid | output | 1 | Result valid |
| result | output | 32 | Shifted/rotated value |
| cf_out | output | 1 | Updated carry flag |

## Verification
The unit holds no state beyond its output register. Any wrong internal decision therefore shows at the ports in the cycle right after the operation that triggered it. A bad count reduction, modulo or fill choice shows up as a wrong `result` or `cf_out` at exactly one (size, opcode, count) point. Sweeping every size, every opcode and all 32 count values against several data patterns and both carry values leaves no such point unvisited. Hold behaviour is checked by changing the inputs with `in_valid` low and reading the outputs again.

// File: rtl/shrot_pkg.sv
package shrot_pkg;
  localparam int unsigned OP_W = 4;
  localparam int unsigned SZ_W = 2;

  typedef enum logic [OP_W-1:0] {
    OP_LSL = 4'd0,
    OP_LSR = 4'd1,
    OP_ASL = 4'd2,
    OP_ASR = 4'd3,
    OP_ROL = 4'd4,
    OP_ROR = 4'd5,
    OP_RCL = 4'd6,
    OP_RCR = 4'd7,
    OP_FSL = 4'd8,
    OP_FSR = 4'd9
  } shrot_op_e;

  typedef enum logic [SZ_W-1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } shrot_sz_e;
endpackage

// File: rtl/shrot_count.sv
module shrot_count #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 8,
  localparam int unsigned AMT_W = $clog2(DATA_W),
  localparam int unsigned WID_W = AMT_W + 1
) (
  input  logic [CNT_W-1:0]          count,
  input  logic [shrot_pkg::SZ_W-1:0] size,
  output logic [WID_W-1:0]          width,
  output logic [DATA_W-1:0]         mask,
  output logic [AMT_W-1:0]          amt,
  output logic [AMT_W-1:0]          rot_amt,
  output logic [AMT_W-1:0]          ring_amt,
  output logic                      amt_zero
);
  import shrot_pkg::*;

  logic unused_count_hi;
  assign unused_count_hi = ^count[CNT_W-1:AMT_W];

  assign amt      = count[AMT_W-1:0];
  assign amt_zero = (amt == '0);

  always_comb begin
    case (size)
      SZ_BYTE: begin
        width    = WID_W'(8);
        rot_amt  = amt & AMT_W'(7);
        ring_amt = amt % AMT_W'(9);
      end
      SZ_HALF: begin
        width    = WID_W'(16);
        rot_amt  = amt & AMT_W'(15);
        ring_amt = amt % AMT_W'(17);
      end
      default: begin
        width    = WID_W'(DATA_W);
        rot_amt  = amt;
        ring_amt = amt;
      end
    endcase
  end

  assign mask = (width == WID_W'(DATA_W)) ? '1
              : ((DATA_W'(1) << width) - DATA_W'(1));
endmodule

// File: rtl/shrot_shift.sv
module shrot_shift #(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned AMT_W = $clog2(DATA_W),
  localparam int unsigned WID_W = AMT_W + 1,
  localparam int unsigned EXT_W = 3 * DATA_W
) (
  input  logic [shrot_pkg::OP_W-1:0] op,
  input  logic [WID_W-1:0]          width,
  input  logic [DATA_W-1:0]         mask,
  input  logic [AMT_W-1:0]          amt,
  input  logic [DATA_W-1:0]         dst_m,
  input  logic [DATA_W-1:0]         src_m,
  output logic [DATA_W-1:0]         res,
  output logic                      cf
);
  import shrot_pkg::*;

  logic [DATA_W-1:0] fill_l, fill_r, sign_bits;
  logic [EXT_W-1:0]  lx, ly, lbit, rx, ry;
  logic              sign, go_left;

  always_comb begin
    // left family: destination sits above a 32-bit fill area
    fill_l  = (op == OP_FSL) ? (src_m << (WID_W'(DATA_W) - width)) : '0;
    lx      = (EXT_W'(dst_m) << DATA_W) | EXT_W'(fill_l);
    ly      = lx << amt;
    lbit    = ly >> (int'(width) + int'(DATA_W));

    // right family: fill sits just above the destination, guard bit below
    sign_bits = dst_m >> (width - WID_W'(1));
    sign      = sign_bits[0];
    if (op == OP_ASR)      fill_r = {DATA_W{sign}};
    else if (op == OP_FSR) fill_r = src_m;
    else                   fill_r = '0;
    rx = (EXT_W'(fill_r) << (int'(width) + 1)) | (EXT_W'(dst_m) << 1);
    ry = rx >> amt;

    go_left = (op == OP_LSL) || (op == OP_ASL) || (op == OP_FSL);
    if (go_left) begin
      res = DATA_W'(ly >> DATA_W) & mask;
      cf  = lbit[0];
    end else begin
      res = DATA_W'(ry >> 1) & mask;
      cf  = ry[0];
    end
  end
endmodule

// File: rtl/shrot_rotate.sv
module shrot_rotate #(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned AMT_W = $clog2(DATA_W),
  localparam int unsigned WID_W = AMT_W + 1,
  localparam int unsigned RING_W = 2 * DATA_W + 2
) (
  input  logic [shrot_pkg::OP_W-1:0] op,
  input  logic [WID_W-1:0]          width,
  input  logic [DATA_W-1:0]         mask,
  input  logic [AMT_W-1:0]          rot_amt,
  input  logic [AMT_W-1:0]          ring_amt,
  input  logic [DATA_W-1:0]         dst_m,
  input  logic                      cf_in,
  output logic [DATA_W-1:0]         res,
  output logic                      cf
);
  import shrot_pkg::*;

  logic [DATA_W-1:0] rl, rr, rr_top;
  logic [RING_W-1:0] ring, ring_mask, gl, gr, ring_res, ring_top;
  int                n, k;

  always_comb begin
    rl     = ((dst_m << rot_amt) | (dst_m >> (width - WID_W'(rot_amt)))) & mask;
    rr     = ((dst_m >> rot_amt) | (dst_m << (width - WID_W'(rot_amt)))) & mask;
    rr_top = rr >> (width - WID_W'(1));

    n         = int'(width) + 1;
    k         = int'(ring_amt);
    ring      = RING_W'(dst_m) | (RING_W'(cf_in) << width);
    ring_mask = (RING_W'(1) << n) - RING_W'(1);
    gl        = ((ring << k) | (ring >> (n - k))) & ring_mask;
    gr        = ((ring >> k) | (ring << (n - k))) & ring_mask;
    ring_res  = (op == OP_RCL) ? gl : gr;
    ring_top  = ring_res >> width;

    case (op)
      OP_ROL:  begin res = rl; cf = rl[0]; end
      OP_ROR:  begin res = rr; cf = rr_top[0]; end
      default: begin res = DATA_W'(ring_res) & mask; cf = ring_top[0]; end
    endcase
  end
endmodule

// File: rtl/shrot_unit.sv
module shrot_unit #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 8,
  localparam int unsigned AMT_W = $clog2(DATA_W),
  localparam int unsigned WID_W = AMT_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [3:0]        op,
  input  logic [1:0]        size,
  input  logic [DATA_W-1:0] dst,
  input  logic [DATA_W-1:0] src,
  input  logic [CNT_W-1:0]  count,
  input  logic              cf_in,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic              cf_out
);
  import shrot_pkg::*;

  logic [WID_W-1:0]  width;
  logic [DATA_W-1:0] mask, dst_m, src_m;
  logic [AMT_W-1:0]  amt, rot_amt, ring_amt;
  logic              amt_zero;
  logic [DATA_W-1:0] sh_res, ro_res, nxt_res;
  logic              sh_cf, ro_cf, nxt_cf;
  logic              is_funnel, is_rot, keep;

  shrot_count #(.DATA_W(DATA_W), .CNT_W(CNT_W)) count_i (
    .count    (count),
    .size     (size),
    .width    (width),
    .mask     (mask),
    .amt      (amt),
    .rot_amt  (rot_amt),
    .ring_amt (ring_amt),
    .amt_zero (amt_zero)
  );

  assign dst_m = dst & mask;
  assign src_m = src & mask;

  shrot_shift #(.DATA_W(DATA_W)) shift_i (
    .op    (op),
    .width (width),
    .mask  (mask),
    .amt   (amt),
    .dst_m (dst_m),
    .src_m (src_m),
    .res   (sh_res),
    .cf    (sh_cf)
  );

  shrot_rotate #(.DATA_W(DATA_W)) rotate_i (
    .op       (op),
    .width    (width),
    .mask     (mask),
    .rot_amt  (rot_amt),
    .ring_amt (ring_amt),
    .dst_m    (dst_m),
    .cf_in    (cf_in),
    .res      (ro_res),
    .cf       (ro_cf)
  );

  always_comb begin
    is_funnel = (op == OP_FSL) || (op == OP_FSR);
    is_rot    = (op == OP_ROL) || (op == OP_ROR) || (op == OP_RCL) || (op == OP_RCR);
    keep      = amt_zero || (op > OP_FSR) || (is_funnel && (size == SZ_BYTE));
    if (keep) begin
      nxt_res = dst_m;
      nxt_cf  = cf_in;
    end else if (is_rot) begin
      nxt_res = ro_res;
      nxt_cf  = ro_cf;
    end else begin
      nxt_res = sh_res;
      nxt_cf  = sh_cf;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      cf_out    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= nxt_res;
        cf_out <= nxt_cf;
      end
    end
  end
endmodule

// File: rtl/shrot_unit_chk.sv
module shrot_unit_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 8,
  localparam int unsigned AMT_W = $clog2(DATA_W)
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [3:0]        op,
  input logic [1:0]        size,
  input logic [DATA_W-1:0] dst,
  input logic [DATA_W-1:0] src,
  input logic [CNT_W-1:0]  count,
  input logic              cf_in,
  input logic              out_valid,
  input logic [DATA_W-1:0] result,
  input logic              cf_out
);
  logic [1:0]        sz_q;
  logic [DATA_W-1:0] dmask;
  logic              top_bit;
  logic              unused_src;

  assign unused_src = ^src;

  always_ff @(posedge clk) begin
    if (rst) sz_q <= 2'd0;
    else     sz_q <= size;
  end

  always_comb begin
    case (size)
      2'd0:    dmask = DATA_W'(8'hFF);
      2'd1:    dmask = DATA_W'(16'hFFFF);
      default: dmask = '1;
    endcase
    case (sz_q)
      2'd0:    top_bit = result[7];
      2'd1:    top_bit = result[15];
      default: top_bit = result[DATA_W-1];
    endcase
  end

  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  // R1
  idle_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(result) && $stable(cf_out)));
  // R2
  zero_count_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && count[AMT_W-1:0] == '0) |=>
      (result == $past(dst & dmask) && cf_out == $past(cf_in)));
  // R3
  byte_upper_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && sz_q == 2'd0) |-> (result[DATA_W-1:8] == '0));
  // R7
  rol_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 4'd4 && count[AMT_W-1:0] != '0) |=> (cf_out == result[0]));
  // R8
  ror_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 4'd5 && count[AMT_W-1:0] != '0) |=> (cf_out == top_bit));
  // R12
  narrow_funnel_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && size == 2'd0 && (op == 4'd8 || op == 4'd9)) |=>
      (result == $past(dst & dmask) && cf_out == $past(cf_in)));
endmodule

bind shrot_unit shrot_unit_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) chk_i (.*);

// File: tb/shrot_unit_tb.sv
module shrot_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [3:0]  op;
  logic [1:0]  size;
  logic [31:0] dst, src;
  logic [7:0]  count;
  logic        cf_in;
  logic        out_valid;
  logic [31:0] result;
  logic        cf_out;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shrot_unit dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .size(size),
    .dst(dst), .src(src), .count(count), .cf_in(cf_in),
    .out_valid(out_valid), .result(result), .cf_out(cf_out)
  );

  function automatic int width_of(input logic [1:0] s);
    return (s == 2'd0) ? 8 : (s == 2'd1) ? 16 : 32;
  endfunction

  // Step-by-step reference: applies one-bit moves count times.
  task automatic model(input logic [3:0] o, input logic [1:0] s, input logic [31:0] d,
                       input logic [31:0] sr, input logic [7:0] cnt, input logic c0,
                       output logic [31:0] r, output logic co);
    int w;
    int n;
    logic [31:0] m, v, q;
    logic t, c;
    w = width_of(s);
    m = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    v = d & m;
    q = sr & m;
    c = c0;
    n = int'(cnt & 8'd31);
    if (o > 4'd9 || ((o == 4'd8 || o == 4'd9) && w == 8)) n = 0;
    for (int i = 0; i < n; i++) begin
      case (o)
        4'd0, 4'd2: begin c = v[w-1]; v = (v << 1) & m; end
        4'd1:       begin c = v[0]; v = v >> 1; end
        4'd3:       begin c = v[0]; v = (v >> 1) | (32'(v[w-1]) << (w-1)); end
        4'd4:       begin t = v[w-1]; v = ((v << 1) | 32'(t)) & m; c = t; end
        4'd5:       begin t = v[0]; v = (v >> 1) | (32'(t) << (w-1)); c = t; end
        4'd6:       begin t = v[w-1]; v = ((v << 1) | 32'(c)) & m; c = t; end
        4'd7:       begin t = v[0]; v = (v >> 1) | (32'(c) << (w-1)); c = t; end
        4'd8:       begin c = v[w-1]; v = ((v << 1) | 32'(q[w-1])) & m; q = (q << 1) & m; end
        default:    begin c = v[0]; v = (v >> 1) | (32'(q[0]) << (w-1)); q = q >> 1; end
      endcase
    end
    r  = v;
    co = c;
  endtask

  function automatic string tag_of(input logic [3:0] o, input logic [1:0] s, input logic [7:0] cnt);
    if (o > 4'd9 || (s == 2'd0 && (o == 4'd8 || o == 4'd9))) return "R12";
    if ((cnt & 8'd31) == 8'd0) return "R2";
    case (o)
      4'd0, 4'd2: return "R4";
      4'd1:       return "R5";
      4'd3:       return "R6";
      4'd4:       return "R7";
      4'd5:       return "R8";
      4'd6, 4'd7: return "R9";
      4'd8:       return "R10";
      default:    return "R11";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] er, input logic ec, input logic ev);
    total++;
    if (result !== er || cf_out !== ec || out_valid !== ev) begin
      bad++;
      $display("FAIL %s: result=%h cf=%b valid=%b expected result=%h cf=%b valid=%b",
               tag, result, cf_out, out_valid, er, ec, ev);
    end
  endtask

  // Drive one operation after a falling edge, sample at the next falling edge.
  task automatic run_op(input logic [3:0] o, input logic [1:0] s, input logic [31:0] d,
                        input logic [31:0] sr, input logic [7:0] cnt, input logic c0,
                        input string tag, input logic use_lit, input logic [31:0] lit_r,
                        input logic lit_c);
    logic [31:0] er;
    logic ec;
    in_valid = 1'b1; op = o; size = s; dst = d; src = sr; count = cnt; cf_in = c0;
    model(o, s, d, sr, cnt, c0, er, ec);
    if (use_lit) begin er = lit_r; ec = lit_c; end
    @(negedge clk);
    check(tag, er, ec, 1'b1);
  endtask

  logic [31:0] pats [8];

  initial begin
    pats[0] = 32'h0000_0000; pats[1] = 32'hFFFF_FFFF;
    pats[2] = 32'h9BA6_AC36; pats[3] = 32'h234B_7654;
    pats[4] = 32'h8000_0001; pats[5] = 32'h3F5A_0C81;
    pats[6] = 32'h7FFF_8000; pats[7] = 32'hC3E1_F00F;

    rst = 1'b1; in_valid = 1'b1; op = 4'd4; size = 2'd2;
    dst = 32'hDEAD_BEEF; src = 32'h1234_5678; count = 8'd3; cf_in = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset", 32'h0, 1'b0, 1'b0);
    rst = 1'b0;

    // R7, R10, R11: worked examples
    run_op(4'd4, 2'd0, 32'h0000_003F, 32'h0, 8'd4, 1'b0, "R7 example", 1'b1, 32'h0000_00F3, 1'b1);
    run_op(4'd8, 2'd1, 32'h0000_9BA6, 32'h0000_AC36, 8'd4, 1'b0, "R10 example", 1'b1, 32'h0000_BA6A, 1'b1);
    run_op(4'd9, 2'd1, 32'h0000_234B, 32'h0000_7654, 8'd4, 1'b0, "R11 example", 1'b1, 32'h0000_4234, 1'b1);
    // R3: upper input bits ignored, upper output bits zero; size code 3 acts as 32
    run_op(4'd0, 2'd0, 32'hABCD_EF81, 32'h0, 8'd1, 1'b0, "R3 byte", 1'b1, 32'h0000_0002, 1'b1);
    run_op(4'd1, 2'd3, 32'h8000_0000, 32'h0, 8'd31, 1'b0, "R3 size3", 1'b1, 32'h0000_0001, 1'b0);
    // R2: upper count bits ignored
    run_op(4'd3, 2'd1, 32'h0000_8000, 32'h0, 8'hE2, 1'b0, "R2 count mask", 1'b1, 32'h0000_E000, 1'b0);

    // R1: hold while idle
    in_valid = 1'b0; op = 4'd0; dst = 32'h5555_5555; count = 8'd7; cf_in = 1'b0;
    @(negedge clk);
    check("R1 hold", 32'h0000_E000, 1'b0, 1'b0);
    @(negedge clk);
    check("R1 hold2", 32'h0000_E000, 1'b0, 1'b0);

    // Sweep: every size, opcode, count, several data patterns, both carries
    for (int sz = 0; sz < 3; sz++) begin
      for (int o = 0; o < 16; o++) begin
        for (int c = 0; c < 32; c++) begin
          for (int p = 0; p < 8; p++) begin
            for (int cv = 0; cv < 2; cv++) begin
              logic [7:0] cnt;
              cnt = 8'(c) | 8'(((p * 3) % 8) << 5);
              run_op(4'(o), 2'(sz), pats[p], pats[(p + 3) % 8], cnt, 1'(cv),
                     tag_of(4'(o), 2'(sz), cnt), 1'b0, 32'h0, 1'b0);
            end
          end
        end
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule